// File: doc/BRIEF.md
# Source Operand Fetch With Constant Generator

This sequential unit resolves the source operand of a two-operand or single-operand instruction. Its inputs are a 2-bit addressing-mode code, a 4-bit source register number and a byte/word flag. It returns the operand value together with a one-cycle completion pulse.

Depending on the mode and the register, the operand comes from one of three places:
- the register itself;
- a small constant built in from register numbers 2 and 3, with no memory access;
- one memory read through a synchronous word-read port.

The memory read may be preceded by the fetch of one extension word from the instruction stream. For autoincrement modes the unit also requests a write-back of the stepped register. It reports how many extension words it consumed and the program-counter value that follows them.

The surrounding core drives the selected register's value on `reg_val_i` and the address of the next instruction-stream word on `pc_i` in the cycle `start_i` is high. The unit captures both in that cycle. Destination handling and the arithmetic unit sit elsewhere.

Top module: `src_operand_fetch`

## Requirements
- R1: While reset is held and after it is released, `done_o`, `mem_rd_o` and `reg_wr_o` are 0 until a start is accepted.
- R2: Mode 00 with any register other than 3 returns the register value, with `done_o` high in the cycle after start and no memory read.
- R3: Register 3 yields constants 0, 1, 2 and 0xFFFF for modes 00, 01, 10 and 11. Register 2 yields 4 for mode 10 and 8 for mode 11. These finish in the cycle after start, with no memory read and an extension count of 0.
- R4: Mode 10 (registers other than 2 and 3) reads memory at the register value and completes on the third cycle after start.
- R5: In byte mode (`byte_i`=1) a memory operand is the byte at the read address, where address bit 0 = 1 selects bits 15:8, zero-extended. Register, constant and immediate operands keep only bits 7:0.
- R6: Mode 11 with a register other than 0, 2 or 3 reads like mode 10. With `done_o` it also pulses `reg_wr_o`, with `reg_wr_idx_o` equal to the register and `reg_wr_val_o` equal to its value plus 1 (byte) or plus 2 (word), wrapping at 16 bits.
- R7: Mode 01 (not register 3) first reads an extension word at `pc_i`. It then reads the operand at the extension word plus the register value, or at the extension word alone for register 2. It completes on the fifth cycle after start.
- R8: Mode 11 with register 0 returns the extension word read at `pc_i` as the operand, issues no second read and requests no register write. It completes on the third cycle after start.
- R9: With `done_o`, `ext_cnt_o` equals the number of extension words read (0 or 1), and `pc_next_o` equals `pc_i` plus 2 per extension word, independent of byte mode.
- R10: A start that arrives while a fetch is in progress is ignored. The fetch in progress is unchanged and no extra operation follows it.
- R11: `mem_rd_o` is high for one cycle per read with `mem_addr_o` valid. The data is taken from `mem_rdata_i` one cycle later, and a read never coincides with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for one operand fetch |
| as_i | input | 2 | Source addressing-mode code |
| sreg_i | input | 4 | Source register number |
| byte_i | input | 1 | 1 = byte operation, 0 = word operation |
| reg_val_i | input | 16 | Contents of the source register |
| pc_i | input | 16 | Address of the next instruction-stream word |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read strobe |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 16 | Memory read address |
| opnd_o | output | 16 | Resolved operand, valid with done |
| done_o | output | 1 | One-cycle completion pulse |
| reg_wr_o | output | 1 | Autoincrement write-back request |
| reg_wr_idx_o | output | 4 | Register to write back |
| reg_wr_val_o | output | 16 | Stepped register value |
| ext_cnt_o | output | 2 | Extension words consumed by this fetch |
| pc_next_o | output | 16 | Program counter after the extension words |

## Verification
The hardest situation to reach from the ports is a start that lands in the middle of a multi-cycle fetch, where it must leave no trace. The bench issues a second start, with different mode, register and value inputs, during the extension-word phase of an indexed fetch. It then checks that the read schedule, operand and completion of the original fetch are exactly those predicted. It also checks that no further completion or read appears in the cycle after.

Byte lanes at odd addresses and autoincrement wrap-around at 0xFFFE are driven on purpose, so that lane selection and the write-back step are checked at their edges.

// File: rtl/sof_pkg.sv
package sof_pkg;

  typedef enum logic [2:0] {
    K_REG,
    K_CONST,
    K_IND,
    K_AUTO,
    K_INDEX,
    K_IMM
  } kind_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EXT,
    S_EXTC,
    S_RD,
    S_CAP
  } st_t;

endpackage

// File: rtl/sof_mode_decode.sv
module sof_mode_decode import sof_pkg::*; #(
  parameter int DW     = 16,
  parameter int RW     = 4,
  parameter int PC_IDX = 0,
  parameter int CG1    = 2,
  parameter int CG2    = 3
) (
  input  logic [1:0]    as_i,
  input  logic [RW-1:0] sreg_i,
  output kind_t         kind_o,
  output logic [DW-1:0] cval_o,
  output logic          base_zero_o
);

  always_comb begin
    kind_o      = K_REG;
    cval_o      = '0;
    base_zero_o = 1'b0;
    if (sreg_i == RW'(CG2)) begin
      kind_o = K_CONST;
      case (as_i)
        2'b00:   cval_o = DW'(0);
        2'b01:   cval_o = DW'(1);
        2'b10:   cval_o = DW'(2);
        default: cval_o = '1;
      endcase
    end else if (sreg_i == RW'(CG1) && as_i[1]) begin
      kind_o = K_CONST;
      cval_o = as_i[0] ? DW'(8) : DW'(4);
    end else begin
      case (as_i)
        2'b00: kind_o = K_REG;
        2'b01: begin
          kind_o      = K_INDEX;
          base_zero_o = (sreg_i == RW'(CG1));
        end
        2'b10:   kind_o = K_IND;
        default: kind_o = (sreg_i == RW'(PC_IDX)) ? K_IMM : K_AUTO;
      endcase
    end
  end

endmodule

// File: rtl/sof_lane_pick.sv
module sof_lane_pick #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]                   word_i,
  input  logic [$clog2(DW/8)-1:0]         lane_i,
  input  logic                            byte_i,
  output logic [DW-1:0]                   data_o
);

  localparam int LANES = DW / 8;

  logic [7:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word_i[g*8 +: 8];
  end

  assign data_o = byte_i ? {{(DW-8){1'b0}}, lanes[lane_i]} : word_i;

endmodule

// File: rtl/src_operand_fetch.sv
module src_operand_fetch import sof_pkg::*; #(
  parameter int DW     = 16,
  parameter int AW     = 16,
  parameter int RW     = 4,
  parameter int CW     = 2,
  parameter int PC_IDX = 0,
  parameter int CG1    = 2,
  parameter int CG2    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    as_i,
  input  logic [RW-1:0] sreg_i,
  input  logic          byte_i,
  input  logic [DW-1:0] reg_val_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] opnd_o,
  output logic          done_o,
  output logic          reg_wr_o,
  output logic [RW-1:0] reg_wr_idx_o,
  output logic [AW-1:0] reg_wr_val_o,
  output logic [CW-1:0] ext_cnt_o,
  output logic [AW-1:0] pc_next_o
);

  localparam int LANE_BITS = $clog2(DW/8);

  function automatic logic [DW-1:0] keep_low(input logic [DW-1:0] v, input logic b);
    return b ? {{(DW-8){1'b0}}, v[7:0]} : v;
  endfunction

  function automatic logic [AW-1:0] step_reg(input logic [AW-1:0] r, input logic b);
    return r + (b ? AW'(1) : AW'(2));
  endfunction

  function automatic logic [AW-1:0] pc_advance(input logic [AW-1:0] pc, input logic [CW-1:0] n);
    return pc + (AW'(n) << 1);
  endfunction

  st_t           st;
  kind_t         kind_q;
  logic          byte_q;
  logic [RW-1:0] idx_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] pc_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] opnd_q;
  logic          done_q;
  logic          wr_q;
  logic [AW-1:0] wr_val_q;

  kind_t         kind_d;
  logic [DW-1:0] cval_d;
  logic          base_zero_d;
  logic [DW-1:0] picked;

  // named events for the checker
  logic busy;
  logic accept;
  logic ext_rd;
  logic opnd_rd;

  assign busy    = (st != S_IDLE);
  assign accept  = start_i && !busy;
  assign ext_rd  = (st == S_EXT);
  assign opnd_rd = (st == S_RD);

  sof_mode_decode #(
    .DW(DW), .RW(RW), .PC_IDX(PC_IDX), .CG1(CG1), .CG2(CG2)
  ) u_dec (
    .as_i        (as_i),
    .sreg_i      (sreg_i),
    .kind_o      (kind_d),
    .cval_o      (cval_d),
    .base_zero_o (base_zero_d)
  );

  sof_lane_pick #(.DW(DW)) u_lane (
    .word_i (mem_rdata_i),
    .lane_i (addr_q[LANE_BITS-1:0]),
    .byte_i (byte_q),
    .data_o (picked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind_q   <= K_REG;
      byte_q   <= 1'b0;
      idx_q    <= '0;
      base_q   <= '0;
      addr_q   <= '0;
      pc_q     <= '0;
      cnt_q    <= '0;
      opnd_q   <= '0;
      done_q   <= 1'b0;
      wr_q     <= 1'b0;
      wr_val_q <= '0;
    end else begin
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      case (st)
        S_IDLE: begin
          if (accept) begin
            kind_q <= kind_d;
            byte_q <= byte_i;
            idx_q  <= sreg_i;
            pc_q   <= pc_i;
            cnt_q  <= '0;
            base_q <= base_zero_d ? '0 : AW'(reg_val_i);
            case (kind_d)
              K_REG: begin
                opnd_q <= keep_low(reg_val_i, byte_i);
                done_q <= 1'b1;
              end
              K_CONST: begin
                opnd_q <= keep_low(cval_d, byte_i);
                done_q <= 1'b1;
              end
              K_IND, K_AUTO: begin
                addr_q <= AW'(reg_val_i);
                st     <= S_RD;
              end
              default: begin
                addr_q <= pc_i;
                st     <= S_EXT;
              end
            endcase
          end
        end
        S_EXT: begin
          cnt_q <= cnt_q + CW'(1);
          st    <= S_EXTC;
        end
        S_EXTC: begin
          if (kind_q == K_IMM) begin
            opnd_q <= keep_low(mem_rdata_i, byte_q);
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            addr_q <= base_q + AW'(mem_rdata_i);
            st     <= S_RD;
          end
        end
        S_RD: st <= S_CAP;
        S_CAP: begin
          opnd_q <= picked;
          done_q <= 1'b1;
          if (kind_q == K_AUTO) begin
            wr_q     <= 1'b1;
            wr_val_q <= step_reg(base_q, byte_q);
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_rd_o     = ext_rd || opnd_rd;
  assign mem_addr_o   = addr_q;
  assign opnd_o       = opnd_q;
  assign done_o       = done_q;
  assign reg_wr_o     = wr_q;
  assign reg_wr_idx_o = idx_q;
  assign reg_wr_val_o = wr_val_q;
  assign ext_cnt_o    = cnt_q;
  assign pc_next_o    = pc_advance(pc_q, cnt_q);

endmodule

// File: rtl/sof_checker.sv
module sof_checker #(
  parameter int RW = 4,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [1:0]    as_i,
  input logic [RW-1:0] sreg_i,
  input logic          busy,
  input logic          done_o,
  input logic          mem_rd_o,
  input logic          reg_wr_o,
  input logic [RW-1:0] reg_wr_idx_o,
  input logic [CW-1:0] ext_cnt_o
);

  logic fast_case;
  assign fast_case = (as_i == 2'b00) || (sreg_i == RW'(3)) || (sreg_i == RW'(2) && as_i[1]);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!done_o && !mem_rd_o && !reg_wr_o); // R1
    end
  end

  AST_FAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy && fast_case) |=> (done_o && !mem_rd_o)); // R3

  AST_FAST_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy && fast_case) |=> (ext_cnt_o == '0)); // R9

  AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> done_o); // R6

  AST_WB_NOT_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> (reg_wr_idx_o != RW'(0) && reg_wr_idx_o != RW'(2) && reg_wr_idx_o != RW'(3))); // R6

  AST_RD_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> !done_o); // R11

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !mem_rd_o); // R11

  AST_EXT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ext_cnt_o <= CW'(1))); // R9

endmodule

bind src_operand_fetch sof_checker #(.RW(RW), .CW(CW)) u_sof_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .as_i         (as_i),
  .sreg_i       (sreg_i),
  .busy         (busy),
  .done_o       (done_o),
  .mem_rd_o     (mem_rd_o),
  .reg_wr_o     (reg_wr_o),
  .reg_wr_idx_o (reg_wr_idx_o),
  .ext_cnt_o    (ext_cnt_o)
);

// File: tb/src_operand_fetch_bench.sv
module src_operand_fetch_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  as_i = '0;
  logic [3:0]  sreg_i = '0;
  logic        byte_i = 1'b0;
  logic [15:0] reg_val_i = '0;
  logic [15:0] pc_i = '0;
  logic [15:0] mem_rdata_i = '0;
  logic        mem_rd_o;
  logic [15:0] mem_addr_o;
  logic [15:0] opnd_o;
  logic        done_o;
  logic        reg_wr_o;
  logic [3:0]  reg_wr_idx_o;
  logic [15:0] reg_wr_val_o;
  logic [1:0]  ext_cnt_o;
  logic [15:0] pc_next_o;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  src_operand_fetch u_src_operand_fetch (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .as_i(as_i), .sreg_i(sreg_i),
    .byte_i(byte_i), .reg_val_i(reg_val_i), .pc_i(pc_i), .mem_rdata_i(mem_rdata_i),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .opnd_o(opnd_o), .done_o(done_o),
    .reg_wr_o(reg_wr_o), .reg_wr_idx_o(reg_wr_idx_o), .reg_wr_val_o(reg_wr_val_o),
    .ext_cnt_o(ext_cnt_o), .pc_next_o(pc_next_o)
  );

  // memory content: a computed word per aligned address
  function automatic logic [15:0] memf(input logic [15:0] a);
    logic [15:0] w;
    w = {a[15:1], 1'b0};
    return 16'(w * 37) ^ 16'h5A3C;
  endfunction

  // synchronous read port model
  always @(posedge clk) begin
    if (mem_rd_o) mem_rdata_i <= memf(mem_addr_o);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one operand fetch, compared cycle by cycle with a behavioural model
  task automatic run_op(input logic [1:0] as, input logic [3:0] rn, input bit bm,
                        input logic [15:0] rv, input logic [15:0] pcv,
                        input bit poke, input string tag);
    int lat;
    int rd_k1, rd_k2;
    logic [15:0] a1, a2, expv, ext, tgt, wrv, pcn;
    bit wr;
    int cnt;
    lat = 1; rd_k1 = 0; rd_k2 = 0; a1 = '0; a2 = '0; wr = 0; wrv = '0; cnt = 0; expv = '0;
    if (rn == 4'd3) begin
      expv = (as == 2'd3) ? 16'hFFFF : 16'(as);
      if (bm) expv = {8'h00, expv[7:0]};
    end else if (as == 2'd0) begin
      expv = bm ? {8'h00, rv[7:0]} : rv;
    end else if (rn == 4'd2 && as[1]) begin
      expv = as[0] ? 16'd8 : 16'd4;
    end else if (as == 2'd2 || (as == 2'd3 && rn != 4'd0)) begin
      lat = 3; rd_k1 = 1; a1 = rv;
      expv = bm ? (rv[0] ? {8'h00, memf(rv)[15:8]} : {8'h00, memf(rv)[7:0]}) : memf(rv);
      if (as == 2'd3) begin
        wr = 1;
        wrv = rv + (bm ? 16'd1 : 16'd2);
      end
    end else if (as == 2'd3) begin
      lat = 3; rd_k1 = 1; a1 = pcv; cnt = 1;
      expv = bm ? {8'h00, memf(pcv)[7:0]} : memf(pcv);
    end else begin
      lat = 5; rd_k1 = 1; rd_k2 = 3; a1 = pcv; cnt = 1;
      ext = memf(pcv);
      tgt = ((rn == 4'd2) ? 16'd0 : rv) + ext;
      a2 = tgt;
      expv = bm ? (tgt[0] ? {8'h00, memf(tgt)[15:8]} : {8'h00, memf(tgt)[7:0]}) : memf(tgt);
    end
    pcn = pcv + 16'(2 * cnt);

    @(negedge clk);
    start_i = 1'b1; as_i = as; sreg_i = rn; byte_i = bm; reg_val_i = rv; pc_i = pcv;
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      if (k == 1) start_i = 1'b0;
      if (poke && k == 2) begin
        start_i = 1'b1; as_i = 2'd0; sreg_i = 4'd3; reg_val_i = 16'h7777; pc_i = 16'h1111;
      end
      if (poke && k == 3) start_i = 1'b0;
      chk(mem_rd_o == (k == rd_k1 || k == rd_k2), {tag, " read strobe"}, 32'(mem_rd_o), 32'(k == rd_k1 || k == rd_k2));
      if (k == rd_k1) chk(mem_addr_o == a1, {tag, " first read address"}, 32'(mem_addr_o), 32'(a1));
      if (k == rd_k2 && rd_k2 != 0) chk(mem_addr_o == a2, {tag, " operand address"}, 32'(mem_addr_o), 32'(a2));
      chk(done_o == (k == lat), {tag, " done timing"}, 32'(done_o), 32'(k == lat));
    end
    chk(opnd_o == expv, {tag, " operand"}, 32'(opnd_o), 32'(expv));
    chk(reg_wr_o == wr, {tag, " R6 write request"}, 32'(reg_wr_o), 32'(wr));
    if (wr) begin
      chk(reg_wr_idx_o == rn, {tag, " R6 write index"}, 32'(reg_wr_idx_o), 32'(rn));
      chk(reg_wr_val_o == wrv, {tag, " R6 write value"}, 32'(reg_wr_val_o), 32'(wrv));
    end
    chk(ext_cnt_o == 2'(cnt), {tag, " R9 ext count"}, 32'(ext_cnt_o), 32'(cnt));
    chk(pc_next_o == pcn, {tag, " R9 next pc"}, 32'(pc_next_o), 32'(pcn));
    @(negedge clk);
    chk(!done_o && !mem_rd_o && !reg_wr_o, {tag, " quiet after done"}, {29'd0, done_o, mem_rd_o, reg_wr_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done_o && !mem_rd_o && !reg_wr_o, "R1 reset state", {29'd0, done_o, mem_rd_o, reg_wr_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done_o && !mem_rd_o && !reg_wr_o, "R1 after release", {29'd0, done_o, mem_rd_o, reg_wr_o}, 32'd0);

    run_op(2'd0, 4'd5, 1'b0, 16'h1234, 16'hF800, 0, "R2 register word");
    run_op(2'd0, 4'd5, 1'b1, 16'hABCD, 16'hF800, 0, "R5 register byte");
    run_op(2'd0, 4'd0, 1'b0, 16'hF802, 16'hF802, 0, "R2 pc register");
    run_op(2'd0, 4'd2, 1'b0, 16'h0107, 16'hF800, 0, "R2 status register");
    for (int a = 0; a < 4; a++) run_op(2'(a), 4'd3, 1'b0, 16'h5555, 16'hF800, 0, "R3 constant reg3");
    run_op(2'd3, 4'd3, 1'b1, 16'h5555, 16'hF800, 0, "R5 constant minus one byte");
    run_op(2'd2, 4'd2, 1'b0, 16'h0000, 16'hF800, 0, "R3 constant four");
    run_op(2'd3, 4'd2, 1'b0, 16'h0000, 16'hF800, 0, "R3 constant eight");
    run_op(2'd2, 4'd6, 1'b0, 16'h0300, 16'hF800, 0, "R4 indirect word");
    run_op(2'd2, 4'd6, 1'b1, 16'h0301, 16'hF800, 0, "R5 indirect odd byte");
    run_op(2'd2, 4'd6, 1'b1, 16'h0300, 16'hF800, 0, "R5 indirect even byte");
    run_op(2'd3, 4'd7, 1'b0, 16'h0400, 16'hF800, 0, "R6 autoinc word");
    run_op(2'd3, 4'd7, 1'b1, 16'h0401, 16'hF800, 0, "R6 autoinc byte");
    run_op(2'd3, 4'd9, 1'b0, 16'hFFFE, 16'hF800, 0, "R6 autoinc wrap");
    run_op(2'd1, 4'd4, 1'b0, 16'h0200, 16'hF810, 0, "R7 indexed word");
    run_op(2'd1, 4'd0, 1'b1, 16'hF812, 16'hF812, 0, "R7 symbolic byte");
    run_op(2'd1, 4'd2, 1'b0, 16'h0008, 16'hF820, 0, "R7 absolute");
    run_op(2'd3, 4'd0, 1'b0, 16'hF830, 16'hF830, 0, "R8 immediate word");
    run_op(2'd3, 4'd0, 1'b1, 16'hF832, 16'hF832, 0, "R8 immediate byte");
    run_op(2'd1, 4'd4, 1'b0, 16'h0220, 16'hF840, 1, "R10 start while busy");
    run_op(2'd0, 4'd5, 1'b0, 16'h4242, 16'hF800, 0, "R11 back to back");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule